// File: doc/BRIEF.md
# LIN break generator and detector

This block sits next to an asynchronous UART that is running in LIN mode. It handles the break field only. On request it holds the serial output at the dominant (low) level for a programmed number of bit times. It also watches the serial input for a long low period and reports that as a break.

The block uses the bit-rate tick of the shared baud generator, so every length is counted in bit times. The output pin has a manual override that can force either level. The block also returns the synchronized level of the input pin.

A detected break sets a sticky flag, which can also drive an interrupt request. Once a break has been detected, detection stays disarmed. Software re-arms it by leaving LIN mode, pulsing the unit reset and then selecting LIN mode again.

Top module: `lin_brk_unit`

## Requirements
- R1: The break length code selects how many bit ticks the output stays low: code 0 gives 13, code 1 gives 14, code 2 gives 15 and code 3 gives 16. The low period starts in the cycle after a `brk_req` pulse.
- R2: A `brk_req` that arrives while a break is being sent is ignored. The length of the running break does not change, and no second break follows it.
- R3: When the low period ends, `txd` returns high and `brk_done` is high for exactly one clock cycle. When no break is active and the override is off, `txd` follows `uart_txd`.
- R4: A break is detected when the synchronized input has been low for 11 consecutive bit ticks. A run of 10 low ticks is not a break, and a high level resets the run.
- R5: `brk_irq` is high exactly when `brk_flag` and `irq_en` are both high.
- R6: A `flag_clr` pulse clears `brk_flag` and therefore `brk_irq`.
- R7: After a detection, further low runs do not set the flag again. A `unit_clr` pulse clears the flag, stops any running break and re-arms detection.
- R8: When `lin_mode` is low, `brk_req` has no effect and no break is detected.
- R9: When `ovr_en` is high, `txd` equals `ovr_level`, even during a break. `rxd_level` returns the level of `rxd` two clock cycles later.
- R10: After reset, `brk_flag`, `brk_irq` and `brk_done` are low, and `txd` follows `uart_txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time from the baud generator |
| lin_mode | input | 1 | LIN operating mode selected |
| unit_clr | input | 1 | Unit reset pulse: clears the flag, stops a break, re-arms detection |
| len_code | input | 2 | Break length code (13 + code bit times) |
| brk_req | input | 1 | Pulse that starts a break |
| flag_clr | input | 1 | Pulse that clears the break flag |
| irq_en | input | 1 | Break interrupt enable |
| ovr_en | input | 1 | Output override enable |
| ovr_level | input | 1 | Level forced on the output while the override is on |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |
| rxd_level | output | 1 | Synchronized level of the serial input |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Break interrupt request |
| brk_done | output | 1 | One-cycle pulse at the end of a generated break |

## Verification
An error in the generator's counter or its latched length shows on `txd` as a low period of the wrong length. It is visible at the release edge, at most 16 bit times after the request. The same release edge must line up with the one-cycle `brk_done` pulse.

A detector run counter that is off by one, or that is not cleared by a high level, sets `brk_flag` one bit tick too early or too late. A missing glitch reset shows up as a false flag. A lost arm state shows up in one of two ways: as a second flag after a clear, or as no flag after `unit_clr`. Either one appears within the next 11-tick low run.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  localparam int LEN_CODE_W = 2;
  localparam int LEN_BASE   = 13;
  localparam int DET_TICKS  = 11;

  typedef logic [LEN_CODE_W-1:0] len_code_t;

  function automatic int brk_len(input len_code_t code);
    return LEN_BASE + int'(code);
  endfunction
endpackage

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
  import lin_brk_pkg::*;
#(
  parameter int BASE_LEN = LEN_BASE,
  parameter int CODE_W   = LEN_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              abort,
  input  logic              req,
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic              done
);
  localparam int MAX_LEN = BASE_LEN + (1 << CODE_W) - 1;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic          act_q, act_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_q, last_d;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    done_d = 1'b0;
    if (abort || !en) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (!act_q) begin
      if (req) begin
        act_d  = 1'b1;
        cnt_d  = '0;
        last_d = CW'(BASE_LEN - 1) + CW'(code);
      end
    end else if (tick) begin
      if (cnt_q == last_q) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign active = act_q;
  assign done   = done_q;
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det
  import lin_brk_pkg::*;
#(
  parameter int MIN_TICKS = DET_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic rearm,
  input  logic rxd,
  output logic rxd_sync,
  output logic detect
);
  localparam int RW = $clog2(MIN_TICKS + 1);

  logic          s1_q, s2_q;
  logic          armed_q, armed_d;
  logic [RW-1:0] run_q, run_d;
  logic          hit;

  always_comb begin
    run_d   = run_q;
    armed_d = armed_q;
    hit     = 1'b0;
    if (rearm) begin
      run_d   = '0;
      armed_d = 1'b1;
    end else if (!en || s2_q) begin
      run_d = '0;
    end else if (tick) begin
      if (run_q == RW'(MIN_TICKS - 1) && armed_q) begin
        hit     = 1'b1;
        armed_d = 1'b0;
      end
      if (run_q < RW'(MIN_TICKS)) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      run_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      s1_q    <= rxd;
      s2_q    <= s1_q;
      run_q   <= run_d;
      armed_q <= armed_d;
    end
  end

  assign rxd_sync = s2_q;
  assign detect   = hit;
endmodule

// File: rtl/lin_brk_unit.sv
module lin_brk_unit
  import lin_brk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_tick,
  input  logic                  lin_mode,
  input  logic                  unit_clr,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  brk_req,
  input  logic                  flag_clr,
  input  logic                  irq_en,
  input  logic                  ovr_en,
  input  logic                  ovr_level,
  input  logic                  uart_txd,
  input  logic                  rxd,
  output logic                  txd,
  output logic                  rxd_level,
  output logic                  brk_flag,
  output logic                  brk_irq,
  output logic                  brk_done
);
  logic gen_active;
  logic det_hit;
  logic flag_q, flag_d;

  lin_brk_gen #(.BASE_LEN(LEN_BASE), .CODE_W(LEN_CODE_W)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (lin_mode),
    .tick   (bit_tick),
    .abort  (unit_clr),
    .req    (brk_req),
    .code   (len_code),
    .active (gen_active),
    .done   (brk_done)
  );

  lin_brk_det #(.MIN_TICKS(DET_TICKS)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (lin_mode),
    .tick     (bit_tick),
    .rearm    (unit_clr),
    .rxd      (rxd),
    .rxd_sync (rxd_level),
    .detect   (det_hit)
  );

  always_comb begin
    flag_d = flag_q;
    if (unit_clr)      flag_d = 1'b0;
    else if (det_hit)  flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    if (ovr_en)          txd = ovr_level;
    else if (gen_active) txd = 1'b0;
    else                 txd = uart_txd;
  end

  assign brk_flag = flag_q;
  assign brk_irq  = flag_q & irq_en;
endmodule

// File: rtl/lin_brk_unit_chk.sv
module lin_brk_unit_chk
  import lin_brk_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bit_tick,
  input logic                  lin_mode,
  input logic                  unit_clr,
  input logic [LEN_CODE_W-1:0] len_code,
  input logic                  brk_req,
  input logic                  flag_clr,
  input logic                  irq_en,
  input logic                  ovr_en,
  input logic                  ovr_level,
  input logic                  uart_txd,
  input logic                  rxd,
  input logic                  txd,
  input logic                  rxd_level,
  input logic                  brk_flag,
  input logic                  brk_irq,
  input logic                  brk_done
);
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> brk_flag);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);

  a_r3_done_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_done && !ovr_en && $past(!ovr_en)) |-> ($past(txd) == 1'b0));

  a_r7_clr_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    unit_clr |=> !brk_flag);

  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !lin_mode) |=> !brk_flag);

  a_r8_off_passes_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_mode && $past(!lin_mode) && !ovr_en) |-> (txd == uart_txd));
endmodule

bind lin_brk_unit lin_brk_unit_chk u_chk (.*);

// File: tb/lin_brk_unit_test.sv
`timescale 1ns/1ps
module lin_brk_unit_test;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic lin_mode = 1'b0, unit_clr = 1'b0, brk_req = 1'b0, flag_clr = 1'b0;
  logic irq_en = 1'b0, ovr_en = 1'b0, ovr_level = 1'b1, uart_txd = 1'b1, rxd = 1'b1;
  logic [1:0] len_code = 2'd0;
  logic txd, rxd_level, brk_flag, brk_irq, brk_done;
  int checks = 0, errors = 0, div_cnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    div_cnt  = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    bit_tick = (div_cnt == DIV - 1);
  end

  lin_brk_unit uut (.*);

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int exp_len(input logic [1:0] c);
    return 13 + int'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int left = n;
    while (left > 0) begin
      @(negedge clk);
      if (bit_tick) left--;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // Sends one break; optionally fires a second request mid-break.
  task automatic run_break(input logic [1:0] c, input bit extra);
    int lows = 0, cyc = 0;
    bit seen_done;
    len_code = c;
    @(negedge clk);
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    while (txd == 1'b0 && cyc < 400) begin
      if (bit_tick) lows++;
      if (extra && cyc == 20) begin
        len_code = ~c;
        brk_req  = 1'b1;
      end else begin
        brk_req = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    brk_req = 1'b0;
    chk(lows == exp_len(c), extra ? "R2 length kept" : "R1 break length", lows, exp_len(c));
    seen_done = brk_done;
    chk(seen_done && txd, "R3 done with release", int'(brk_done), 1);
    @(negedge clk);
    chk(!brk_done, "R3 done single cycle", int'(brk_done), 0);
    if (extra) begin
      repeat (40) begin
        @(negedge clk);
        if (txd !== 1'b1) lows = -1;
      end
      chk(lows != -1, "R2 no second break", int'(txd), 1);
    end
  endtask

  // Holds rxd low for n bit ticks, then reports the flag.
  task automatic low_run(input int n, input logic exp_flag, input string req);
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(n);
    @(negedge clk);
    chk(brk_flag == exp_flag, req, int'(brk_flag), int'(exp_flag));
    rxd = 1'b1;
    wait_ticks(2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!brk_flag && !brk_irq && !brk_done, "R10 reset outputs", int'(brk_flag), 0);
    chk(txd == uart_txd, "R10 reset txd", int'(txd), int'(uart_txd));
    rst_n = 1'b1;
    @(negedge clk);
    uart_txd = 1'b0;
    @(negedge clk);
    chk(txd == 1'b0, "R10 txd follows data", int'(txd), 0);
    uart_txd = 1'b1;
    lin_mode = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 4; c++) run_break(2'(c), 1'b0);
    for (int i = 0; i < 4; i++) begin
      logic [1:0] rc;
      logic dv;
      rc = 2'($urandom);
      run_break(rc, 1'b0);
      dv = 1'($urandom);
      uart_txd = dv;
      @(negedge clk);
      chk(txd == dv, "R3 idle txd follows data", int'(txd), int'(dv));
      uart_txd = 1'b1;
    end
    run_break(2'd0, 1'b1);
    run_break(2'd3, 1'b1);

    low_run(10, 1'b0, "R4 ten ticks no break");
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(6);
    rxd = 1'b1;
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(6);
    @(negedge clk);
    chk(!brk_flag, "R4 glitch resets run", int'(brk_flag), 0);
    rxd = 1'b1;
    wait_ticks(2);
    low_run(11, 1'b1, "R4 eleven ticks break");
    chk(!brk_irq, "R5 irq masked", int'(brk_irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(brk_irq, "R5 irq raised", int'(brk_irq), 1);
    pulse(flag_clr);
    chk(!brk_flag && !brk_irq, "R6 flag cleared", int'(brk_flag), 0);
    low_run(14, 1'b0, "R7 disarmed after detect");
    pulse(unit_clr);
    low_run(11, 1'b1, "R7 rearmed by unit reset");
    pulse(unit_clr);
    chk(!brk_flag, "R7 unit reset clears flag", int'(brk_flag), 0);

    len_code = 2'd3;
    brk_req  = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    wait_ticks(2);
    pulse(unit_clr);
    chk(txd == 1'b1, "R7 unit reset stops break", int'(txd), 1);

    ovr_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic lv;
      lv = 1'($urandom);
      ovr_level = lv;
      @(negedge clk);
      chk(txd == lv, "R9 override level", int'(txd), int'(lv));
    end
    ovr_level = 1'b1;
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    wait_ticks(3);
    chk(txd == 1'b1, "R9 override beats break", int'(txd), 1);
    pulse(unit_clr);
    ovr_en = 1'b0;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    chk(rxd_level == 1'b0, "R9 input level low", int'(rxd_level), 0);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk(rxd_level == 1'b1, "R9 input level high", int'(rxd_level), 1);

    lin_mode = 1'b0;
    @(negedge clk);
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    begin
      int bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (txd !== 1'b1 || brk_done) bad++;
      end
      chk(bad == 0, "R8 request ignored off mode", bad, 0);
    end
    low_run(13, 1'b0, "R8 no detect off mode");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule